// File: doc/BRIEF.md
# Hamming (7,4) Single-Error Codec

This block pairs an encoder and a decoder for a single-error-correcting block code that carries 4 data bits and 3 parity bits. The encoder accepts a 4-bit data word with a valid strobe. One clock later it presents a 7-bit systematic code word in which the data bits appear unchanged, followed by three even-parity bits.

The decoder accepts a received 7-bit word with its own valid strobe. It computes a 3-bit syndrome and, one clock later, reports the syndrome, an error flag, a correction flag, the corrected bit position and the recovered data. A static mode input selects the decoder behaviour. In detect-only mode any error is flagged and the data is left as received. In correct mode the single bit that the syndrome names is inverted.

Two bit errors cannot be told apart from one. In correct mode such a word is therefore "repaired" at a wrong position without any extra indication. The mode input is meant to be changed only while no decode is in flight.

Top module: `hamming74_codec`

## Requirements
- R1: The code word places the data unchanged in bits [6:3], with data bit [3] (first data bit) in code bit 6. Code bit 6 is the first transmitted bit, r1, and code bit 0 is r7.
- R2: Code bits [2:0] are the parity bits p1,p2,p3, where p1 = d1^d3^d4, p2 = d1^d2^d4 and p3 = d1^d2^d3. Here d1..d4 are data bits [3],[2],[1],[0].
- R3: enc_valid_out is high exactly one cycle after enc_valid_in was high. The encoded word is valid in that cycle.
- R4: dec_valid_out is high exactly one cycle after dec_valid_in was high. All decoder results are valid in that cycle.
- R5: dec_syndrome[2] = r1^r3^r4^r5, dec_syndrome[1] = r1^r2^r4^r6 and dec_syndrome[0] = r1^r2^r3^r7.
- R6: A zero syndrome gives dec_err=0, dec_fixed=0 and dec_pos=0, and the data is code bits [6:3] unchanged.
- R7: With corr_mode=0, a nonzero syndrome gives dec_err=1, dec_fixed=0 and dec_pos=0, and the data is code bits [6:3] unchanged.
- R8: With corr_mode=1, a nonzero syndrome gives dec_err=1 and dec_fixed=1. dec_pos names the position whose syndrome pattern matches: 111→1, 011→2, 101→3, 110→4, 100→5, 010→6, 001→7. That bit is inverted before the data is taken from bits [6:3]. For example, the word 1011001 gives syndrome 101, position 3 and data 1001.
- R9: With corr_mode=1, a word with two flipped bits is handled exactly as R8 predicts from its syndrome, with dec_err=1, even though the resulting data is wrong.
- R10: A synchronous active-high rst drives both output valids low in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_mode | input | 1 | 1 = correct single errors, 0 = detect only |
| enc_valid_in | input | 1 | Encoder input strobe |
| enc_data_in | input | 4 | Data word to encode |
| enc_valid_out | output | 1 | Encoder output strobe |
| enc_code_out | output | 7 | Code word, r1 in bit 6 |
| dec_valid_in | input | 1 | Decoder input strobe |
| dec_code_in | input | 7 | Received word, r1 in bit 6 |
| dec_valid_out | output | 1 | Decoder output strobe |
| dec_data_out | output | 4 | Recovered data |
| dec_syndrome | output | 3 | Syndrome (s1,s2,s3) in bits [2:0] |
| dec_err | output | 1 | Nonzero syndrome seen |
| dec_fixed | output | 1 | A bit was inverted |
| dec_pos | output | 3 | Inverted position 1..7, 0 if none |

## Verification
Every result of either path is due on the first rising edge after its input strobe is sampled. The bench drives inputs on a falling edge and reads all outputs on the next falling edge, so the sample lands one edge after the stimulus. One cycle after the strobe is dropped, it confirms that the output valid has fallen again. For every data word, each of no error, the 7 single flips and the 21 double flips is decoded in both modes and compared with a bench model. Seeded random words and the worked example are added on top of this sweep.

// File: rtl/hamming74_codec.sv
module hamming74_codec (
  input  logic       clk,
  input  logic       rst,
  input  logic       corr_mode,
  input  logic       enc_valid_in,
  input  logic [3:0] enc_data_in,
  output logic       enc_valid_out,
  output logic [6:0] enc_code_out,
  input  logic       dec_valid_in,
  input  logic [6:0] dec_code_in,
  output logic       dec_valid_out,
  output logic [3:0] dec_data_out,
  output logic [2:0] dec_syndrome,
  output logic       dec_err,
  output logic       dec_fixed,
  output logic [2:0] dec_pos
);

  function automatic logic [2:0] syn_of(input logic [6:0] c);
    return {c[6]^c[4]^c[3]^c[2], c[6]^c[5]^c[3]^c[1], c[6]^c[5]^c[4]^c[0]};
  endfunction

  logic [2:0] par;
  assign par = {enc_data_in[3]^enc_data_in[1]^enc_data_in[0],
                enc_data_in[3]^enc_data_in[2]^enc_data_in[0],
                enc_data_in[3]^enc_data_in[2]^enc_data_in[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid_out <= 1'b0;
      enc_code_out  <= '0;
    end else begin
      enc_valid_out <= enc_valid_in;
      if (enc_valid_in) enc_code_out <= {enc_data_in, par};
    end
  end

  logic [2:0] syn;
  logic [6:0] flip;
  logic [2:0] pos;
  assign syn = syn_of(dec_code_in);

  always_comb begin
    flip = '0;
    pos  = '0;
    if (corr_mode) begin
      for (int k = 1; k <= 7; k++) begin
        if (syn != 3'd0 && syn == syn_of(7'b1 << (7 - k))) begin
          flip = 7'b1 << (7 - k);
          pos  = 3'(k);
        end
      end
    end
  end

  logic [6:0] fixed_word;
  assign fixed_word = dec_code_in ^ flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_out <= 1'b0;
      dec_data_out  <= '0;
      dec_syndrome  <= '0;
      dec_err       <= 1'b0;
      dec_fixed     <= 1'b0;
      dec_pos       <= '0;
    end else begin
      dec_valid_out <= dec_valid_in;
      if (dec_valid_in) begin
        dec_data_out <= fixed_word[6:3];
        dec_syndrome <= syn;
        dec_err      <= syn != 3'd0;
        dec_fixed    <= flip != 7'd0;
        dec_pos      <= pos;
      end
    end
  end

  a_r3_enc_latency: assert property (@(posedge clk) disable iff (rst)
    enc_valid_in |=> enc_valid_out);
  a_r3_enc_idle: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_in |=> !enc_valid_out);
  a_r2_enc_clean: assert property (@(posedge clk) disable iff (rst)
    enc_valid_out |-> syn_of(enc_code_out) == 3'd0);
  a_r4_dec_latency: assert property (@(posedge clk) disable iff (rst)
    dec_valid_in |=> dec_valid_out);
  a_r4_dec_idle: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_in |=> !dec_valid_out);
  a_r6_clean_quiet: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_out && dec_syndrome == 3'd0) |-> (!dec_err && !dec_fixed && dec_pos == 3'd0));
  a_r7_detect_only: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_in && !corr_mode && syn_of(dec_code_in) != 3'd0) |=>
      (dec_err && !dec_fixed && dec_pos == 3'd0 && dec_data_out == $past(dec_code_in[6:3])));
  a_r8_fix_pos: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_out && dec_fixed) |-> (dec_err && dec_pos != 3'd0));
  a_r10_reset: assert property (@(posedge clk)
    $past(rst) |-> (!enc_valid_out && !dec_valid_out));

endmodule

// File: tb/hamming74_codec_bench.sv
`timescale 1ns/1ps
module hamming74_codec_bench;
  logic clk = 0, rst = 1, corr_mode = 0;
  logic enc_valid_in = 0, dec_valid_in = 0;
  logic [3:0] enc_data_in = 0;
  logic [6:0] dec_code_in = 0;
  logic enc_valid_out, dec_valid_out, dec_err, dec_fixed;
  logic [6:0] enc_code_out;
  logic [3:0] dec_data_out;
  logic [2:0] dec_syndrome, dec_pos;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hamming74_codec u_hamming74_codec (
    .clk(clk), .rst(rst), .corr_mode(corr_mode),
    .enc_valid_in(enc_valid_in), .enc_data_in(enc_data_in),
    .enc_valid_out(enc_valid_out), .enc_code_out(enc_code_out),
    .dec_valid_in(dec_valid_in), .dec_code_in(dec_code_in),
    .dec_valid_out(dec_valid_out), .dec_data_out(dec_data_out),
    .dec_syndrome(dec_syndrome), .dec_err(dec_err),
    .dec_fixed(dec_fixed), .dec_pos(dec_pos));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] m_enc(input logic [3:0] d);
    logic d1 = d[3], d2 = d[2], d3 = d[1], d4 = d[0];
    return {d, d1^d3^d4, d1^d2^d4, d1^d2^d3};
  endfunction

  function automatic logic [2:0] m_syn(input logic [6:0] c);
    logic r1 = c[6], r2 = c[5], r3 = c[4], r4 = c[3], r5 = c[2], r6 = c[1], r7 = c[0];
    return {r1^r3^r4^r5, r1^r2^r4^r6, r1^r2^r3^r7};
  endfunction

  function automatic logic [2:0] m_pos(input logic [2:0] s);
    case (s)
      3'b111: return 3'd1;
      3'b011: return 3'd2;
      3'b101: return 3'd3;
      3'b110: return 3'd4;
      3'b100: return 3'd5;
      3'b010: return 3'd6;
      3'b001: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  task automatic do_enc(input logic [3:0] d);
    @(negedge clk);
    enc_valid_in = 1; enc_data_in = d;
    @(negedge clk);
    enc_valid_in = 0;
    chk("R3", "enc_valid_out", enc_valid_out, 1);
    chk("R1", "data field", enc_code_out[6:3], d);
    chk("R2", "parity field", enc_code_out[2:0], m_enc(d) & 7'h7);
    @(negedge clk);
    chk("R3", "enc_valid_out drop", enc_valid_out, 0);
  endtask

  task automatic do_dec(input logic [6:0] c, input string req);
    logic [2:0] s, p;
    logic [6:0] w;
    s = m_syn(c);
    p = corr_mode ? m_pos(s) : 3'd0;
    w = (p != 0) ? (c ^ (7'b1 << (7 - p))) : c;
    @(negedge clk);
    dec_valid_in = 1; dec_code_in = c;
    @(negedge clk);
    dec_valid_in = 0;
    chk("R4", "dec_valid_out", dec_valid_out, 1);
    chk("R5", "syndrome", dec_syndrome, s);
    chk(req, "err", dec_err, s != 0);
    chk(req, "fixed", dec_fixed, corr_mode && s != 0);
    chk(req, "pos", dec_pos, p);
    chk(req, "data", dec_data_out, w[6:3]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1;
    enc_valid_in = 1; dec_valid_in = 1;
    repeat (3) @(negedge clk);
    chk("R10", "enc_valid_out in reset", enc_valid_out, 0);
    chk("R10", "dec_valid_out in reset", dec_valid_out, 0);
    enc_valid_in = 0; dec_valid_in = 0;
    rst = 0;

    corr_mode = 1;
    do_dec(7'b1011001, "R8");
    chk("R8", "example pos", dec_pos, 3);
    chk("R8", "example data", dec_data_out, 4'b1001);

    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      corr_mode = m[0];
      for (int d = 0; d < 16; d++) begin
        do_enc(4'(d));
        do_dec(m_enc(4'(d)), "R6");
        for (int i = 0; i < 7; i++)
          do_dec(m_enc(4'(d)) ^ (7'b1 << i), m ? "R8" : "R7");
        for (int i = 0; i < 7; i++)
          for (int j = i + 1; j < 7; j++)
            do_dec(m_enc(4'(d)) ^ (7'b1 << i) ^ (7'b1 << j), m ? "R9" : "R7");
      end
    end

    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      corr_mode = 1'($urandom);
      do_dec(7'($urandom), corr_mode ? "R8" : "R7");
    end

    @(negedge clk);
    enc_valid_in = 1; dec_valid_in = 1; rst = 1;
    @(negedge clk);
    chk("R10", "enc_valid_out after rst", enc_valid_out, 0);
    chk("R10", "dec_valid_out after rst", dec_valid_out, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule